// File: doc/BRIEF.md
# Extended-Data-Out DRAM Output-Drive Controller

This block models, on the device side, the logic that decides when the data pins of an extended-data-out DRAM drive and when they float. It samples the row strobe, column strobe, output-enable and write-enable levels on a fast system clock. From these it produces a data-pin enable, the value to drive, and a write-capture strobe with the captured write data.

A read keeps driving after the column strobe returns high, so the host can latch data late in the cycle. The output only turns off in defined ways:
- it is gated by output enable or write enable at any moment;
- several sticky conditions, armed during column-strobe-high time, hold the pins off until the next column-strobe fall.

The two output-enable hold minimums are parameters counted in sampling-clock cycles. The memory array, address decoding and analog timing are left to other blocks.

All pin levels are active low except `rd_data`/`dq_in`. Every output is registered: the response to pin levels sampled at one rising clock edge is visible right after that edge.

Top module: `edo_dq_ctrl`

## Requirements
- R1: During and right after synchronous reset, `dq_oe` and `wr_stb` are 0.
- R2: A read access is started by a column-strobe fall sampled with row strobe low and write enable high. While it is in progress, `dq_oe` is 1 exactly when the output-enable level sampled at the previous edge was low.
- R3: A column-strobe rise does not by itself turn the drive off. After a read, `dq_oe` stays 1 while output enable stays low and write enable stays high, even if the row strobe then rises.
- R4: Output enable may be high before the column strobe rises and stay high for at least `TCHO_CYC` samples, counting the rising-edge sample. Then `dq_oe` stays 0, whatever output enable does, until the next column-strobe fall.
- R5: Output enable may be low at the column-strobe rise. Then an output-enable high run of at least `TOEP_CYC` consecutive samples during column-strobe high sets `dq_oe` to 0 until the next column-strobe fall.
- R6: An output-enable high run shorter than the applicable minimum does not arm the sticky disable. `dq_oe` returns to 1 once output enable is low again.
- R7: If write enable is low at the column-strobe fall (early write), `dq_oe` stays 0 for that whole column cycle.
- R8: Write enable sampled low while the column strobe is high sets `dq_oe` to 0 until the next column-strobe fall, even if write enable returns high.
- R9: `wr_stb` pulses for one cycle when row strobe, column strobe and write enable first become low together, which is the later of the column and write falls. `wr_data` then holds `dq_in` from that sample. Two pulses are never adjacent.
- R10: A column-strobe fall sampled with the row strobe high leaves `dq_oe` at 0. `dq_oe` is also 0 whenever the column strobe is low and the row strobe is high.
- R11: `dq_out` takes `rd_data` at every edge where the column strobe is sampled low, and holds its value at every edge where it is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe level, active low |
| cas_n | input | 1 | Column strobe level, active low |
| oe_n | input | 1 | Output enable level, active low |
| we_n | input | 1 | Write enable level, active low |
| rd_data | input | DW | Read data from the array |
| dq_in | input | DW | Data present on the pins for writing |
| dq_oe | output | 1 | Data pin drive enable |
| dq_out | output | DW | Value to drive on the data pins |
| wr_stb | output | 1 | One-cycle write capture strobe |
| wr_data | output | DW | Captured write data |

## Verification
Every result (`dq_oe`, `dq_out`, `wr_stb`, `wr_data`) is due in the cycle after the edge that samples the causing pin levels. The sticky disables follow the same rule: they take effect after the edge holding the last sample of a qualifying high run. The bench drives pins on the falling clock edge and updates its reference model on the rising edge. It compares on the next falling edge, so every comparison lands exactly one register stage after its stimulus. Directed checks of hold-run lengths are taken after a stated number of steps counted from the pin change.

// File: rtl/edo_pkg.sv
// Shared type for the edo_dq_ctrl block: one sample of the four strobe pins.
package edo_pkg;

    // Active-low strobe levels as seen at one clock edge.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
        logic we_n;
    } strobes_t;

    // Idle (all deasserted) strobe sample used at reset.
    localparam strobes_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/edo_pin_sampler.sv
// Registers the strobe levels once per clock so that the other units can
// compare the new sample with the one taken at the previous edge.
// Assumes the pins are already synchronous to clk.
module edo_pin_sampler
    import edo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  strobes_t pins_i,
    output strobes_t last_o
);

    // Hold the previous sample; idle levels out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) last_o <= STROBES_IDLE;
        else        last_o <= pins_i;
    end

endmodule

// File: rtl/edo_hiz_arbiter.sv
// Tracks whether read data is valid and whether a sticky high-impedance
// condition has been armed during column-strobe-high time.
//
// Armed by:
//   - output enable high before the column rise and held TCHO_CYC samples;
//   - an output-enable pulse of TOEP_CYC samples;
//   - write enable low.
// All of these are cleared at the next column fall.
// Assumes TCHO_CYC and TOEP_CYC are at least 1.
module edo_hiz_arbiter
    import edo_pkg::*;
#(
    parameter int TCHO_CYC = 2,
    parameter int TOEP_CYC = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  strobes_t now_i,
    input  logic     was_cas_n,
    input  logic     was_oe_n,
    output logic     rd_valid_o,
    output logic     kill_o
);

    localparam int CMAX = (TCHO_CYC > TOEP_CYC) ? TCHO_CYC : TOEP_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(CMAX);
    localparam logic [CW-1:0] RUN_TCHO = CW'(TCHO_CYC);
    localparam logic [CW-1:0] RUN_TOEP = CW'(TOEP_CYC);

    logic [CW-1:0] run_q, run_d;
    logic          from_rise_q, from_rise_d;
    logic          kill_q, kill_d;
    logic          valid_q, valid_d;
    logic          cas_fall, cas_rise;

    // Column strobe edges between the previous and the current sample.
    always_comb begin
        cas_fall = was_cas_n & ~now_i.cas_n;
        cas_rise = ~was_cas_n & now_i.cas_n;
    end

    // Next-state rules for the output-enable run, sticky kill and read validity.
    always_comb begin
        run_d       = run_q;
        from_rise_d = from_rise_q;
        kill_d      = kill_q;
        valid_d     = valid_q;
        if (cas_fall) begin
            run_d       = '0;
            from_rise_d = 1'b0;
            kill_d      = 1'b0;
            valid_d     = ~now_i.ras_n & now_i.we_n;
        end else if (now_i.cas_n) begin
            if (cas_rise) begin
                from_rise_d = now_i.oe_n & was_oe_n;
                run_d       = now_i.oe_n ? CW'(1) : '0;
            end else if (now_i.oe_n) begin
                run_d = (run_q == RUN_MAX) ? run_q : run_q + CW'(1);
            end else begin
                run_d       = '0;
                from_rise_d = 1'b0;
            end
            if (now_i.oe_n && ((from_rise_d && run_d >= RUN_TCHO) ||
                               (!from_rise_d && run_d >= RUN_TOEP)))
                kill_d = 1'b1;
            if (!now_i.we_n)
                kill_d = 1'b1;
        end else if (!now_i.we_n) begin
            valid_d = 1'b0;
        end
    end

    // State registers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            from_rise_q <= 1'b0;
            kill_q      <= 1'b0;
            valid_q     <= 1'b0;
        end else begin
            run_q       <= run_d;
            from_rise_q <= from_rise_d;
            kill_q      <= kill_d;
            valid_q     <= valid_d;
        end
    end

    assign rd_valid_o = valid_q;
    assign kill_o     = kill_q;

endmodule

// File: rtl/edo_write_latch.sv
// Produces a one-cycle write strobe when row strobe, column strobe and write
// enable first become low together, and captures the pin data at that sample.
// This marks the later of the column and write falls.
// Assumes the write data is valid in the same sample as that event.
module edo_write_latch #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          was_ras_n,
    input  logic          was_cas_n,
    input  logic          was_we_n,
    input  logic [DW-1:0] dq_in,
    output logic          wr_stb_o,
    output logic [DW-1:0] wr_data_o
);

    logic go_now, go_was;

    // Write condition in the current and the previous sample.
    always_comb begin
        go_now = ~ras_n & ~cas_n & ~we_n;
        go_was = ~was_ras_n & ~was_cas_n & ~was_we_n;
    end

    // Pulse and capture on the first sample of the write condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o <= go_now & ~go_was;
            if (go_now && !go_was) wr_data_o <= dq_in;
        end
    end

endmodule

// File: rtl/edo_read_hold.sv
// Holds the read value for the data pins. It follows the array data while the
// column strobe is low and freezes while it is high, which keeps data valid
// past the column rise. Assumes rd_data is valid whenever the column strobe is low.
module edo_read_hold #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cas_n,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] dq_out_o
);

    // One register per data bit, loaded while the column strobe is low.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      dq_out_o[b] <= 1'b0;
            else if (!cas_n) dq_out_o[b] <= rd_data[b];
        end
    end

endmodule

// File: rtl/edo_dq_ctrl.sv
// Top of the extended-data-out output-drive controller.
// Samples the strobes, combines read validity, sticky disables and the live
// output-enable and write-enable levels into one pin drive enable, and
// exposes the write capture.
// Assumes all strobe inputs are synchronous to clk.
module edo_dq_ctrl
    import edo_pkg::*;
#(
    parameter int DW       = 4,
    parameter int TCHO_CYC = 2,
    parameter int TOEP_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] dq_in,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    output logic          wr_stb,
    output logic [DW-1:0] wr_data
);

    strobes_t pins, last;
    logic     rd_valid, kill;

    // Bundle the pins into one sample.
    always_comb begin
        pins.ras_n = ras_n;
        pins.cas_n = cas_n;
        pins.oe_n  = oe_n;
        pins.we_n  = we_n;
    end

    edo_pin_sampler u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .last_o (last)
    );

    edo_hiz_arbiter #(
        .TCHO_CYC (TCHO_CYC),
        .TOEP_CYC (TOEP_CYC)
    ) u_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_i      (pins),
        .was_cas_n  (last.cas_n),
        .was_oe_n   (last.oe_n),
        .rd_valid_o (rd_valid),
        .kill_o     (kill)
    );

    edo_write_latch #(.DW(DW)) u_wlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .was_ras_n (last.ras_n),
        .was_cas_n (last.cas_n),
        .was_we_n  (last.we_n),
        .dq_in     (dq_in),
        .wr_stb_o  (wr_stb),
        .wr_data_o (wr_data)
    );

    edo_read_hold #(.DW(DW)) u_rhold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_n    (cas_n),
        .rd_data  (rd_data),
        .dq_out_o (dq_out)
    );

    // Drive only valid, unkilled read data with OE low, W high, and no column access under a high row strobe.
    always_comb begin
        dq_oe = rd_valid & ~kill & last.we_n & ~last.oe_n & (last.cas_n | ~last.ras_n);
    end

endmodule

// File: rtl/edo_dq_ctrl_chk.sv
// Assertion checker for edo_dq_ctrl, attached by bind. Observes ports only.
module edo_dq_ctrl_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          wr_stb
);

    // Drive only after a sample with output enable low and write enable high.
    assert_drive_needs_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!$past(oe_n) && $past(we_n)));

    // No drive after a sample with column low and row high.
    assert_no_drive_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ($past(cas_n) || !$past(ras_n)));

    // Write strobe only after a sample with all three strobes low.
    assert_wr_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!$past(ras_n) && !$past(cas_n) && !$past(we_n)));

    // Write strobe is a single-cycle pulse.
    assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // Read value frozen across an edge that sampled the column strobe high.
    assert_hold_when_cas_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n) |-> $stable(dq_out));

endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .dq_oe  (dq_oe),
    .dq_out (dq_out),
    .wr_stb (wr_stb)
);

// File: tb/edo_dq_ctrl_tb.sv
// Self-checking bench: behavioural reference model compared every cycle,
// plus directed checks on the expected drive state per requirement.
module edo_dq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 4;
    localparam int TCHO = 2;
    localparam int TOEP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [DW-1:0] rd_data = '0, dq_in = '0;
    logic dq_oe, wr_stb;
    logic [DW-1:0] dq_out, wr_data;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_dq_ctrl #(.DW(DW), .TCHO_CYC(TCHO), .TOEP_CYC(TOEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
        .we_n(we_n), .rd_data(rd_data), .dq_in(dq_in), .dq_oe(dq_oe),
        .dq_out(dq_out), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    // Reference model state (integers, behavioural).
    int p_ras = 1, p_cas = 1, p_oe = 1, p_we = 1;
    int valid = 0, killed = 0, hi_run = 0, began_at_rise = 0, p_go = 0;
    int m_oe = 0, m_stb = 0;
    int m_out = 0, m_wdat = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            p_ras = 1; p_cas = 1; p_oe = 1; p_we = 1;
            valid = 0; killed = 0; hi_run = 0; began_at_rise = 0; p_go = 0;
            m_stb = 0; m_out = 0; m_wdat = 0;
        end else begin
            int go;
            go = (ras_n == 0 && cas_n == 0 && we_n == 0) ? 1 : 0;
            m_stb = (go == 1 && p_go == 0) ? 1 : 0;
            if (m_stb == 1) m_wdat = int'(dq_in);
            p_go = go;
            if (cas_n == 0) m_out = int'(rd_data);
            if (p_cas == 1 && cas_n == 0) begin
                killed = 0; hi_run = 0; began_at_rise = 0;
                valid = (ras_n == 0 && we_n == 1) ? 1 : 0;
            end else if (cas_n == 1) begin
                if (p_cas == 0) begin
                    began_at_rise = (oe_n == 1 && p_oe == 1) ? 1 : 0;
                    hi_run = oe_n ? 1 : 0;
                end else if (oe_n == 1) hi_run++;
                else begin hi_run = 0; began_at_rise = 0; end
                if (began_at_rise == 1 && hi_run >= TCHO) killed = 1;
                if (began_at_rise == 0 && hi_run >= TOEP) killed = 1;
                if (we_n == 0) killed = 1;
            end else if (we_n == 0) valid = 0;
            p_ras = ras_n; p_cas = cas_n; p_oe = oe_n; p_we = we_n;
        end
        m_oe = (valid == 1 && killed == 0 && p_we == 1 && p_oe == 0 &&
                (p_cas == 1 || p_ras == 0)) ? 1 : 0;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "model dq_oe",   int'(dq_oe),   m_oe);
            check(phase, "model wr_stb",  int'(wr_stb),  m_stb);
            check(phase, "model dq_out",  int'(dq_out),  m_out);
            check(phase, "model wr_data", int'(wr_data), m_wdat);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1: reset state
        check("R1", "dq_oe in reset", int'(dq_oe), 0);
        check("R1", "wr_stb in reset", int'(wr_stb), 0);
        rst_n = 1'b1;
        step(1);
        check("R1", "dq_oe after reset", int'(dq_oe), 0);

        // R2: read access, OE controls drive
        phase = "R2";
        ras_n = 0; step(1);
        cas_n = 0; oe_n = 0; rd_data = 4'hA; step(1);
        check("R2", "drive on read", int'(dq_oe), 1);
        check("R11", "data on read", int'(dq_out), 4'hA);
        oe_n = 1; step(1);
        check("R2", "OE high floats", int'(dq_oe), 0);
        oe_n = 0; step(1);
        check("R2", "OE low drives again", int'(dq_oe), 1);

        // R3 / R11: column rise keeps drive and data
        phase = "R3";
        cas_n = 1; rd_data = 4'h3; step(2);
        check("R3", "drive past CAS rise", int'(dq_oe), 1);
        check("R11", "data held past CAS rise", int'(dq_out), 4'hA);

        // R6: short OE pulse in CAS high does not arm
        phase = "R6";
        oe_n = 1; step(TOEP - 1);
        oe_n = 0; step(1);
        check("R6", "short OE pulse", int'(dq_oe), 1);

        // R5: full-length OE pulse arms sticky off
        phase = "R5";
        oe_n = 1; step(TOEP);
        oe_n = 0; step(1);
        check("R5", "OE pulse sticky", int'(dq_oe), 0);
        step(2);
        check("R5", "still off", int'(dq_oe), 0);

        // R4: OE high across CAS rise for tCHO
        phase = "R4";
        rd_data = 4'h6; cas_n = 0; step(1);
        check("R2", "new read drives", int'(dq_oe), 1);
        check("R11", "new read data", int'(dq_out), 4'h6);
        oe_n = 1; step(1);
        cas_n = 1; step(TCHO);
        oe_n = 0; step(1);
        check("R4", "OE hold sticky", int'(dq_oe), 0);

        // R6: OE held for less than tCHO after rise
        phase = "R6";
        cas_n = 0; step(1);
        oe_n = 1; step(1);
        cas_n = 1; step(TCHO - 1);
        oe_n = 0; step(1);
        check("R6", "short tCHO hold", int'(dq_oe), 1);

        // R8: W low in CAS high is sticky
        phase = "R8";
        we_n = 0; step(1);
        check("R8", "W low off", int'(dq_oe), 0);
        we_n = 1; step(1);
        check("R8", "off after W high", int'(dq_oe), 0);

        // R7 / R9: early write
        phase = "R7";
        we_n = 0; dq_in = 4'h5; step(1);
        cas_n = 0; step(1);
        check("R9", "early write strobe", int'(wr_stb), 1);
        check("R9", "early write data", int'(wr_data), 4'h5);
        check("R7", "early write off", int'(dq_oe), 0);
        we_n = 1; step(1);
        check("R7", "off rest of cycle", int'(dq_oe), 0);
        check("R9", "strobe single", int'(wr_stb), 0);

        // R9: late write (W falls after CAS)
        phase = "R9";
        cas_n = 1; step(1);
        cas_n = 0; rd_data = 4'h9; step(1);
        check("R2", "read before late write", int'(dq_oe), 1);
        dq_in = 4'hC; we_n = 0; step(1);
        check("R9", "late write strobe", int'(wr_stb), 1);
        check("R9", "late write data", int'(wr_data), 4'hC);
        check("R9", "late write off", int'(dq_oe), 0);
        we_n = 1; cas_n = 1; step(1);

        // R3: hold survives RAS rise
        phase = "R3";
        cas_n = 0; rd_data = 4'hE; step(1);
        check("R2", "read drives", int'(dq_oe), 1);
        cas_n = 1; step(1);
        ras_n = 1; step(2);
        check("R3", "hold past RAS rise", int'(dq_oe), 1);
        check("R11", "data past RAS rise", int'(dq_out), 4'hE);
        oe_n = 1; step(TOEP);
        oe_n = 0; step(1);
        check("R5", "pulse off with RAS high", int'(dq_oe), 0);

        // R10: CAS fall with RAS high (refresh) never drives
        phase = "R10";
        cas_n = 0; step(1);
        check("R10", "no drive refresh", int'(dq_oe), 0);
        step(2);
        check("R10", "no drive refresh later", int'(dq_oe), 0);
        cas_n = 1; step(2);
        check("R10", "no drive after refresh", int'(dq_oe), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule